// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit turns the packed partial remainders left behind by a BCH remainder engine into the complete set of 2t syndromes over GF(2^m). It serves the decode side of a flash error-correction path. Once a sector has been read and its remainders are available, a single start pulse makes the unit evaluate every odd syndrome bit by bit through an antilog table. It then derives every even syndrome by squaring a lower syndrome in the log domain. The finished syndrome file goes to the error-locator solver, which is a separate block.

The log and antilog tables sit outside the unit and are read combinationally through address/data port pairs. The remainder words are read the same way. The field is either GF(2^13) with primitive polynomial x^13+x^4+x^3+x+1 (hex 0x201b), used for 512-byte sectors, or GF(2^14) with primitive polynomial 0x4443, used for 1024-byte sectors. The unit runs a fixed schedule, so its latency depends only on the strength and the field.

Top module: `bch_syn_expand`

## Requirements
- R1: After reset, `done` is low and every syndrome entry in `syn_flat` reads zero.
- R2: A `start` pulse seen in idle latches `strength_sel` and `wide_field`. Strength codes 0,1,2,3,4,5 select t = 2,4,8,12,24,32, and codes 6 and 7 select t = 32. `wide_field` = 0 selects m = 13 and n = 8191, and 1 selects m = 14 and n = 16383. The table ports return `alog_data` = alpha^`alog_addr` and `log_data` = log_alpha(`log_addr`).
- R3: Partial remainder k (k = 0..t-1) is read from word k/2 through `rem_addr`. It takes bits [31:16] when k is odd and bits [15:0] when k is even. Only its bits m-1..0 are used; higher bits have no effect.
- R4: Odd syndrome S[2k+1] equals the XOR of alpha^(((2k+1)·j) mod n) over every set bit j of partial remainder k.
- R5: Every address driven on `alog_addr` is below n.
- R6: For j = 1..t in increasing order, S[2j] is 0 when S[j] is 0 and antilog[(2·log S[j]) mod n] otherwise. This equals S[j] squared.
- R7: Every entry is cleared when a computation begins, so entries above 2t read zero on completion.
- R8: `done` is high for exactly one cycle. It is high during the cycle that follows clock edge L = 1 + t·(m+1) + 2t, counting the edge that samples `start` as edge 0.
- R9: A `start` pulse while a computation is running is ignored. The latency and the results stay those of the running computation.
- R10: After `done`, the syndromes stay unchanged until the next accepted start.
- R11: Syndrome s (1..64) sits at `syn_flat[(s-1)*14 +: 14]`. With m = 13, bit 13 of every entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation (accepted in idle only) |
| strength_sel | input | 3 | Strength code |
| wide_field | input | 1 | 0: GF(2^13), 1: GF(2^14) |
| rem_addr | output | 4 | Remainder word index |
| rem_word | input | 32 | Remainder word, two partials packed |
| alog_addr | output | 14 | Antilog table address |
| alog_data | input | 14 | Antilog table data |
| log_addr | output | 14 | Log table address |
| log_data | input | 14 | Log table data |
| done | output | 1 | One-cycle completion pulse |
| syn_flat | output | 896 | All 64 syndrome entries, flattened |

## Verification
Each odd syndrome takes one load cycle and m evaluation cycles. Each even syndrome takes a log-read cycle and an antilog-write cycle. Together with one clear cycle, this puts `done` exactly L edges after the edge that samples `start`. The reference model computes L from t and m and compares `done` at every falling edge, so a pulse that comes early, comes late or lasts two cycles is caught. The full syndrome file is compared in the `done` cycle against values computed with independent field multiplication, and compared again several idle cycles later to confirm it holds. The antilog address range is compared on every falling edge.

// File: rtl/bch_syn_pkg.sv
// Shared types and helpers for the syndrome expansion unit.
// Assumes at most 32-bit strength and fields no wider than 16 bits.
package bch_syn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD,
        ST_BITS,
        ST_EVA,
        ST_EVB,
        ST_DONE
    } syn_state_e;

    // Strength code to correction capability t.
    function automatic int unsigned strength_of(logic [2:0] code);
        case (code)
            3'd0:    return 2;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 12;
            3'd4:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/syn_exp_step.sv
// Running exponent e = (i * j) mod n for successive j.
// Adds the odd index on every step and folds once; assumes inc < n.
module syn_exp_step #(
    parameter int MMAX = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            step_en,
    input  logic [MMAX-1:0] inc,
    input  logic [MMAX-1:0] n,
    output logic [MMAX-1:0] e
);
    logic [MMAX-1:0] e_q;
    logic [MMAX:0]   sum;
    logic [MMAX-1:0] e_next;

    // One modular addition per step.
    always_comb begin
        sum    = {1'b0, e_q} + {1'b0, inc};
        e_next = (sum >= {1'b0, n}) ? MMAX'(sum - {1'b0, n}) : sum[MMAX-1:0];
    end

    // Exponent register, zeroed at the start of each odd syndrome.
    always_ff @(posedge clk) begin
        if (!rst_n)       e_q <= '0;
        else if (init)    e_q <= '0;
        else if (step_en) e_q <= e_next;
    end

    assign e = e_q;

    assert_exp_reduced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (e_q < n));
endmodule

// File: rtl/syn_square.sv
// Log-domain squaring: doubles a discrete log modulo n and registers it
// together with a zero flag for the operand. Assumes logv < n.
module syn_square #(
    parameter int MMAX = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MMAX-1:0] logv,
    input  logic            zero_in,
    input  logic [MMAX-1:0] n,
    output logic [MMAX-1:0] dbl,
    output logic            zero
);
    logic [MMAX:0]   twice;
    logic [MMAX-1:0] dbl_next;
    logic [MMAX-1:0] dbl_q;
    logic            zero_q;

    // 2*log folded once into 0..n-1.
    always_comb begin
        twice    = {logv, 1'b0};
        dbl_next = (twice >= {1'b0, n}) ? MMAX'(twice - {1'b0, n}) : twice[MMAX-1:0];
    end

    // Holding register between log read and antilog read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl_q  <= '0;
            zero_q <= 1'b1;
        end else if (load) begin
            dbl_q  <= dbl_next;
            zero_q <= zero_in;
        end
    end

    assign dbl  = dbl_q;
    assign zero = zero_q;

    assert_double_reduced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dbl_q < n));
endmodule

// File: rtl/syn_regfile.sv
// Syndrome storage, entries 1..2*TMAX, one write port, one read port,
// synchronous clear of every entry and a flattened view of all entries.
module syn_regfile #(
    parameter int TMAX = 32,
    parameter int MMAX = 14,
    localparam int NENT = 2 * TMAX,
    localparam int IW   = $clog2(NENT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [MMAX-1:0]      wr_data,
    input  logic [IW-1:0]        rd_idx,
    output logic [MMAX-1:0]      rd_data,
    output logic [NENT*MMAX-1:0] flat
);
    logic [MMAX-1:0] ent [NENT];

    for (genvar s = 0; s < NENT; s++) begin : g_ent
        // Entry s holds syndrome s+1.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                        ent[s] <= '0;
            else if (wr_en && wr_idx == IW'(s + 1))     ent[s] <= wr_data;
        end
        assign flat[s*MMAX +: MMAX] = ent[s];
    end

    // Combinational read of one entry; index 0 reads zero.
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NENT; s++)
            if (rd_idx == IW'(s + 1)) rd_data = ent[s];
    end
endmodule

// File: rtl/bch_syn_expand.sv
// Expands packed BCH partial remainders into 2t syndromes.
// Odd syndromes: bit-serial antilog accumulation, one table read per cycle.
// Even syndromes: log read, doubling, antilog read, in increasing index.
// Assumes combinational table and remainder ports, and MMAX <= 16.
module bch_syn_expand
    import bch_syn_pkg::*;
#(
    parameter int TMAX     = 32,
    parameter int M_NARROW = 13,
    parameter int M_WIDE   = 14,
    localparam int MMAX = M_WIDE,
    localparam int NENT = 2 * TMAX,
    localparam int IW   = $clog2(NENT + 1),
    localparam int TW   = $clog2(TMAX + 1),
    localparam int KW   = $clog2(TMAX),
    localparam int RAW  = KW - 1,
    localparam int JW   = $clog2(MMAX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           strength_sel,
    input  logic                 wide_field,
    output logic [RAW-1:0]       rem_addr,
    input  logic [31:0]          rem_word,
    output logic [MMAX-1:0]      alog_addr,
    input  logic [MMAX-1:0]      alog_data,
    output logic [MMAX-1:0]      log_addr,
    input  logic [MMAX-1:0]      log_data,
    output logic                 done,
    output logic [NENT*MMAX-1:0] syn_flat
);
    syn_state_e      state_q, state_d;
    logic [TW-1:0]   t_q, t_d, t_pick;
    logic            m14_q, m14_d;
    logic [KW-1:0]   k_q, k_d;
    logic [JW-1:0]   j_q, j_d;
    logic [TW-1:0]   ej_q, ej_d;
    logic [15:0]     p_q, p_d;
    logic [MMAX-1:0] acc_q, acc_d, acc_next;

    logic [MMAX-1:0] field_n;
    logic [JW-1:0]   m_last;
    logic [IW-1:0]   odd_idx, even_idx;
    logic [15:0]     half;
    logic            last_k;

    logic            rf_clear, rf_wr;
    logic [IW-1:0]   rf_idx;
    logic [MMAX-1:0] rf_data, rf_rd;
    logic            step_init, step_en;
    logic [MMAX-1:0] step_e;
    logic            sq_load, sq_zero;
    logic [MMAX-1:0] sq_dbl;

    // Field size, bit count and index helpers derived from the latched config.
    always_comb begin
        field_n  = m14_q ? MMAX'((1 << M_WIDE) - 1) : MMAX'((1 << M_NARROW) - 1);
        m_last   = m14_q ? JW'(M_WIDE - 1) : JW'(M_NARROW - 1);
        odd_idx  = IW'({k_q, 1'b0}) + IW'(1);
        even_idx = IW'({ej_q, 1'b0});
        last_k   = (TW'(k_q) == t_q - TW'(1));
        half     = k_q[0] ? rem_word[31:16] : rem_word[15:0];
        t_pick   = (strength_of(strength_sel) > TMAX) ? TW'(TMAX)
                                                      : TW'(strength_of(strength_sel));
    end

    assign rem_addr = k_q[KW-1:1];

    syn_exp_step #(.MMAX(MMAX)) i_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (step_init),
        .step_en (step_en),
        .inc     (MMAX'(odd_idx)),
        .n       (field_n),
        .e       (step_e)
    );

    syn_square #(.MMAX(MMAX)) i_square (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sq_load),
        .logv    (log_data),
        .zero_in (rf_rd == '0),
        .n       (field_n),
        .dbl     (sq_dbl),
        .zero    (sq_zero)
    );

    syn_regfile #(.TMAX(TMAX), .MMAX(MMAX)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rf_clear),
        .wr_en   (rf_wr),
        .wr_idx  (rf_idx),
        .wr_data (rf_data),
        .rd_idx  (IW'(ej_q)),
        .rd_data (rf_rd),
        .flat    (syn_flat)
    );

    // Sequencer: clear, odd accumulation per remainder, even squaring, done.
    always_comb begin
        state_d   = state_q;
        t_d       = t_q;
        m14_d     = m14_q;
        k_d       = k_q;
        j_d       = j_q;
        ej_d      = ej_q;
        p_d       = p_q;
        acc_d     = acc_q;
        rf_clear  = 1'b0;
        rf_wr     = 1'b0;
        rf_idx    = '0;
        rf_data   = '0;
        step_init = 1'b0;
        step_en   = 1'b0;
        sq_load   = 1'b0;
        alog_addr = '0;
        log_addr  = '0;
        acc_next  = acc_q ^ (p_q[j_q] ? alog_data : '0);
        case (state_q)
            ST_IDLE: if (start) begin
                t_d     = t_pick;
                m14_d   = wide_field;
                state_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                rf_clear = 1'b1;
                k_d      = '0;
                state_d  = ST_LOAD;
            end
            ST_LOAD: begin
                p_d       = half;
                acc_d     = '0;
                j_d       = '0;
                step_init = 1'b1;
                state_d   = ST_BITS;
            end
            ST_BITS: begin
                alog_addr = step_e;
                step_en   = 1'b1;
                if (j_q == m_last) begin
                    rf_wr   = 1'b1;
                    rf_idx  = odd_idx;
                    rf_data = acc_next;
                    if (last_k) begin
                        ej_d    = TW'(1);
                        state_d = ST_EVA;
                    end else begin
                        k_d     = k_q + KW'(1);
                        state_d = ST_LOAD;
                    end
                end else begin
                    j_d   = j_q + JW'(1);
                    acc_d = acc_next;
                end
            end
            ST_EVA: begin
                log_addr = rf_rd;
                sq_load  = 1'b1;
                state_d  = ST_EVB;
            end
            ST_EVB: begin
                alog_addr = sq_dbl;
                rf_wr     = 1'b1;
                rf_idx    = even_idx;
                rf_data   = sq_zero ? '0 : alog_data;
                if (ej_q == t_q) begin
                    state_d = ST_DONE;
                end else begin
                    ej_d    = ej_q + TW'(1);
                    state_d = ST_EVA;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            t_q     <= '0;
            m14_q   <= 1'b0;
            k_q     <= '0;
            j_q     <= '0;
            ej_q    <= '0;
            p_q     <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            t_q     <= t_d;
            m14_q   <= m14_d;
            k_q     <= k_d;
            j_q     <= j_d;
            ej_q    <= ej_d;
            p_q     <= p_d;
            acc_q   <= acc_d;
        end
    end

    assign done = (state_q == ST_DONE);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cfg_held_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(t_q) && $stable(m14_q)));

    assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> ((rf_idx != '0) && (rf_idx <= IW'({t_q, 1'b0}))));

    assert_even_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVB && ej_q != t_q) |=>
            (state_q == ST_EVA && ej_q == $past(ej_q) + TW'(1)));
endmodule

// File: tb/test_bch_syn_expand.sv
module test_bch_syn_expand;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    strength_sel = 3'd0;
    logic          wide_field = 1'b0;
    logic [3:0]    rem_addr;
    logic [31:0]   rem_word;
    logic [MW-1:0] alog_addr, alog_data, log_addr, log_data;
    logic          done;
    logic [64*MW-1:0] syn_flat;

    logic [31:0] rem_mem [16];
    int m_cur = 13;
    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int exp_s [1:64];
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int gf_mulx(int x, int m);
        int r;
        r = x << 1;
        if ((r >> m) & 1) r = r ^ ((m == 13) ? 'h201b : 'h4443);
        return r;
    endfunction

    function automatic int gf_mul(int a, int b, int m);
        int r;
        r = 0;
        for (int i = m - 1; i >= 0; i--) begin
            r = gf_mulx(r, m);
            if ((b >> i) & 1) r = r ^ a;
        end
        return r;
    endfunction

    function automatic int alpha_pow(int e, int m);
        int r, base;
        r = 1;
        base = 2;
        for (int b = 0; b < 15; b++) begin
            if ((e >> b) & 1) r = gf_mul(r, base, m);
            base = gf_mul(base, base, m);
        end
        return r;
    endfunction

    function automatic int gf_log(int x, int m);
        int p, n;
        if (x == 0) return 0;
        n = (1 << m) - 1;
        p = 1;
        for (int i = 0; i < n; i++) begin
            if (p == x) return i;
            p = gf_mulx(p, m);
        end
        return 0;
    endfunction

    assign rem_word  = rem_mem[rem_addr];
    assign alog_data = MW'(alpha_pow(int'(alog_addr), m_cur));
    assign log_data  = MW'(gf_log(int'(log_addr), m_cur));

    bch_syn_expand i_bch_syn_expand (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .strength_sel (strength_sel),
        .wide_field   (wide_field),
        .rem_addr     (rem_addr),
        .rem_word     (rem_word),
        .alog_addr    (alog_addr),
        .alog_data    (alog_data),
        .log_addr     (log_addr),
        .log_data     (log_data),
        .done         (done),
        .syn_flat     (syn_flat)
    );

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int syn_at(int s);
        return int'(syn_flat[(s-1)*MW +: MW]);
    endfunction

    function automatic int t_of(int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 12;
            4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // Reference syndromes from the requirements (R3, R4, R6, R7).
    task automatic build_expected(int t, int m);
        int n, p, w;
        n = (1 << m) - 1;
        for (int s = 1; s <= 64; s++) exp_s[s] = 0;
        for (int k = 0; k < t; k++) begin
            w = int'(rem_mem[k/2]);
            p = ((k % 2) == 1) ? ((w >> 16) & 'hffff) : (w & 'hffff);
            p = p & n;
            for (int j = 0; j < m; j++)
                if ((p >> j) & 1)
                    exp_s[2*k+1] = exp_s[2*k+1] ^ alpha_pow(((2*k+1) * j) % n, m);
        end
        for (int j = 1; j <= t; j++)
            exp_s[2*j] = (exp_s[j] == 0) ? 0 : gf_mul(exp_s[j], exp_s[j], m);
    endtask

    task automatic compare_all(int t, string tag);
        for (int s = 1; s <= 64; s++) begin
            if (s > 2*t)          check({tag, " R7 high entry"}, syn_at(s), exp_s[s]);
            else if (s % 2 == 1)  check({tag, " R4 odd syndrome"}, syn_at(s), exp_s[s]);
            else                  check({tag, " R6 even syndrome"}, syn_at(s), exp_s[s]);
        end
    endtask

    // One computation; poke > 0 injects a second start at that cycle (R9).
    task automatic run(int code, int wide, int poke);
        int t, m, n, lat;
        t = t_of(code);
        m = wide ? 14 : 13;
        n = (1 << m) - 1;
        lat = 1 + t * (m + 1) + 2 * t;
        build_expected(t, m);
        m_cur = m;
        @(negedge clk);
        strength_sel = 3'(code);
        wide_field   = wide[0];
        start        = 1'b1;
        for (int c = 0; c <= lat + 1; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 0) start = 1'b0;
            if (poke > 0 && c == poke) begin
                start = 1'b1;
                strength_sel = 3'(code ^ 3);
                wide_field = ~wide[0];
            end
            if (poke > 0 && c == poke + 1) start = 1'b0;
            // R8: done only in the cycle after edge lat.
            check("R8 done timing", int'(done), (c == lat) ? 1 : 0);
            // R5: antilog address below n.
            check("R5 antilog range", int'(alog_addr < MW'(n)), 1);
            if (c == lat) compare_all(t, "done");
        end
        repeat (4) @(negedge clk);
        check("R10 done stays low", int'(done), 0);
        compare_all(t, "R10 held");
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rem_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 done after reset", int'(done), 0);
        check("R1 syndromes after reset", int'(syn_flat == '0), 1);
        check("R11 flat width", $bits(syn_flat), 64 * MW);

        // R2/R3/R4: t=2, narrow field, random words.
        for (int i = 0; i < 16; i++) rem_mem[i] = next_rand();
        run(0, 0, 0);

        // R6: zero remainders give zero syndromes, t=4 wide.
        for (int i = 0; i < 16; i++) rem_mem[i] = '0;
        run(1, 1, 0);

        // R3: all ones, bits above m must be ignored, t=8 narrow.
        for (int i = 0; i < 16; i++) rem_mem[i] = 32'hffff_ffff;
        run(2, 0, 0);

        // R4: single-bit partials, t=12 wide.
        for (int i = 0; i < 16; i++) rem_mem[i] = (32'h1 << (i % 14)) | (32'h1 << (16 + (i + 5) % 14));
        run(3, 1, 0);

        // R9: extra start during a t=24 narrow run.
        for (int i = 0; i < 16; i++) rem_mem[i] = next_rand();
        run(4, 0, 40);

        // R2: t=32 wide, random.
        for (int i = 0; i < 16; i++) rem_mem[i] = next_rand();
        run(5, 1, 0);

        // R2: code 7 selects t=32, narrow.
        for (int i = 0; i < 16; i++) rem_mem[i] = next_rand();
        run(7, 0, 0);

        // R7: short run after a full one clears the high entries.
        for (int i = 0; i < 16; i++) rem_mem[i] = next_rand();
        run(0, 1, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule